// File: doc/BRIEF.md
# Reference Voltage Margin Sweep Controller

This controller moves an 8-bit wiper code that sets a receiver reference voltage, and it runs a full stress-pattern pass at every code it visits. A sweep starts at the mid-scale nominal code and walks one code at a time, either upward or downward, as selected by `dir_up`. After each code change it waits a programmable number of settling cycles. It then starts the external pattern engine and waits for that engine to report completion.

The first pass that reports an error ends the sweep. The controller then records the failing code, its signed distance from nominal and the identifier of the pattern that failed. A sweep that reaches the end of the code range with no error also ends, and it records the end code with a no-fail status.

Two further modes reuse the same step machinery. Loop mode keeps the wiper at nominal and repeats the full pattern set until told to stop. Scope mode returns the wiper to the recorded failing code and replays only the recorded failing pattern, again until told to stop. At reset the wiper takes a power-on default code, which is fixed by a parameter.

Top module: `vref_sweep_ctrl`

## Requirements
- R1: After reset, `wiper_code` equals the power-on default (127 with default parameters), `busy` is 0, `pe_start` is 0, and `res_code` is 127 with `res_offset` 0.
- R2: In sweep mode (`mode` 0 or 3), the first pass runs at nominal code 127, and every pass is a full-set pass (`pe_single` = 0).
- R3: In sweep mode, an error-free pass that is not at the range end moves `wiper_code` by exactly one code: up when `dir_up` = 1, down when `dir_up` = 0.
- R4: In sweep mode, a pass that ends with `pe_err` = 1 ends the sweep. `res_code` takes the failing code, `res_offset` takes the failing code minus 127 as 9-bit two's complement, `res_pat` takes `pe_err_pat`, and `res_fail` = 1.
- R5: In sweep mode, an error-free pass at code 255 going up, or at code 0 going down, ends the sweep with `res_fail` = 0, `res_code` set to that end code, `res_offset` set to +128 or -127, and `res_pat` = 0.
- R6: After each code change, `pe_start` is asserted exactly `settle_cycles` clock cycles after the first cycle in which the new code is visible on `wiper_code`.
- R7: Loop mode (`mode` = 1) holds `wiper_code` at 127 and repeats full-set passes. A reported error does not end the run. The run ends at the end of the first pass during which `stop` is high when the engine reports done.
- R8: Scope mode (`mode` = 2) sets `wiper_code` to `res_code` and drives `pe_single` = 1 with `pe_pat` = `res_pat`. It repeats single-pattern passes until `stop` is seen at the end of a pass.
- R9: `busy` rises on the clock edge that accepts `start` and stays high until termination. A `start` pulse while `busy` is high is ignored.
- R10: `pe_start` is a one-cycle pulse, issued once per pass, and only while `busy` is high. `busy` falls only on the edge that samples `pe_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run in the selected mode (ignored while busy) |
| mode | input | 2 | 0/3 sweep, 1 loop, 2 scope |
| dir_up | input | 1 | Sweep direction, 1 = toward 255 |
| stop | input | 1 | Ends loop or scope mode at the end of a pass |
| settle_cycles | input | 16 | Settling wait after each code change |
| wiper_code | output | 8 | Potentiometer wiper code |
| busy | output | 1 | High from accepted start until termination |
| pe_start | output | 1 | One-cycle start pulse to the pattern engine |
| pe_single | output | 1 | 1 = run only `pe_pat`, 0 = run the full set |
| pe_pat | output | 4 | Pattern to replay in single mode |
| pe_done | input | 1 | Pattern pass finished (one cycle) |
| pe_err | input | 1 | Pass saw a data error, valid with `pe_done` |
| pe_err_pat | input | 4 | Failing pattern identifier, valid with `pe_done` |
| res_code | output | 8 | Recorded failing or end code |
| res_offset | output | 9 | Recorded code minus nominal, two's complement |
| res_pat | output | 4 | Recorded failing pattern |
| res_fail | output | 1 | 1 = sweep ended on an error |

## Verification
Several pattern-engine error profiles drive the sweep. A threshold a few codes above nominal and one a few codes below show that the direction and the signed offset are recorded correctly. An engine that never fails shows that the sweep stops at both range ends with the no-fail status. An engine that fails on every pass, applied in loop and scope modes, shows that those modes ignore errors and end only on `stop`. A non-zero settling value measures the gap between each code change and the next engine start. A second `start` issued mid-sweep shows that the run already in progress is not disturbed.

// File: rtl/vref_sweep_ctrl.sv
module vref_sweep_ctrl #(
  parameter int CODE_W     = 8,
  parameter int NOMINAL    = 127,
  parameter int RESET_CODE = 127,
  parameter int PAT_W      = 4,
  parameter int SETTLE_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              dir_up,
  input  logic              stop,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic [CODE_W-1:0] wiper_code,
  output logic              busy,
  output logic              pe_start,
  output logic              pe_single,
  output logic [PAT_W-1:0]  pe_pat,
  input  logic              pe_done,
  input  logic              pe_err,
  input  logic [PAT_W-1:0]  pe_err_pat,
  output logic [CODE_W-1:0] res_code,
  output logic [CODE_W:0]   res_offset,
  output logic [PAT_W-1:0]  res_pat,
  output logic              res_fail
);
  localparam logic [CODE_W-1:0] NOM   = CODE_W'(NOMINAL);
  localparam logic [CODE_W-1:0] PWRON = CODE_W'(RESET_CODE);
  localparam logic [CODE_W-1:0] TOP   = {CODE_W{1'b1}};
  localparam logic [1:0] M_LOOP  = 2'd1;
  localparam logic [1:0] M_SCOPE = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_RUN} state_t;

  state_t              state;
  logic [1:0]          mode_q;
  logic                up_q;
  logic [SETTLE_W-1:0] cnt;

  wire sweeping = (mode_q != M_LOOP) && (mode_q != M_SCOPE);
  wire at_end   = up_q ? (wiper_code == TOP) : (wiper_code == '0);
  wire [CODE_W:0] off_now = {1'b0, wiper_code} - {1'b0, NOM};

  assign busy      = (state != S_IDLE);
  assign pe_start  = (state == S_SETTLE) && (cnt == settle_cycles);
  assign pe_single = (mode_q == M_SCOPE);
  assign pe_pat    = res_pat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      wiper_code <= PWRON;
      mode_q     <= '0;
      up_q       <= 1'b0;
      cnt        <= '0;
      res_code   <= NOM;
      res_offset <= '0;
      res_pat    <= '0;
      res_fail   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          mode_q     <= mode;
          up_q       <= dir_up;
          cnt        <= '0;
          wiper_code <= (mode == M_SCOPE) ? res_code : NOM;
          state      <= S_SETTLE;
        end
        S_SETTLE: begin
          if (cnt == settle_cycles) state <= S_RUN;
          else cnt <= cnt + 1'b1;
        end
        S_RUN: if (pe_done) begin
          cnt <= '0;
          if (sweeping) begin
            if (pe_err || at_end) begin
              res_code   <= wiper_code;
              res_offset <= off_now;
              res_pat    <= pe_err ? pe_err_pat : '0;
              res_fail   <= pe_err;
              state      <= S_IDLE;
            end else begin
              wiper_code <= up_q ? wiper_code + 1'b1 : wiper_code - 1'b1;
              state      <= S_SETTLE;
            end
          end else begin
            state <= stop ? S_IDLE : S_SETTLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module vref_sweep_ctrl_chk #(
  parameter int CODE_W  = 8,
  parameter int NOMINAL = 127
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] wiper_code,
  input logic              busy,
  input logic              pe_start,
  input logic              pe_done,
  input logic [CODE_W-1:0] res_code,
  input logic [CODE_W:0]   res_offset
);
  localparam logic [CODE_W:0] NOM9 = (CODE_W+1)'(NOMINAL);

  // R3: while a run is active the wiper moves by one code at most
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && wiper_code != $past(wiper_code)) |->
      ((wiper_code - $past(wiper_code)) == CODE_W'(1) ||
       ($past(wiper_code) - wiper_code) == CODE_W'(1)));

  // R10: engine start only inside a run
  a_r10_start_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    pe_start |-> busy);

  // R10: engine start is a single-cycle pulse
  a_r10_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pe_start |=> !pe_start);

  // R10: a run ends only on a completed pass
  a_r10_end_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(pe_done));

  // R4: recorded offset is consistent with the recorded code
  a_r4_offset_match: assert property (@(posedge clk) disable iff (!rst_n)
    res_offset == ({1'b0, res_code} - NOM9));
endmodule

bind vref_sweep_ctrl vref_sweep_ctrl_chk #(.CODE_W(CODE_W), .NOMINAL(NOMINAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .wiper_code(wiper_code), .busy(busy),
  .pe_start(pe_start), .pe_done(pe_done), .res_code(res_code), .res_offset(res_offset)
);

// File: tb/tb_vref_sweep_ctrl.sv
module tb_vref_sweep_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic dir_up = 1'b1;
  logic stop = 1'b0;
  logic [15:0] settle_cycles = 16'd0;
  logic [7:0] wiper_code;
  logic busy, pe_start, pe_single;
  logic [3:0] pe_pat;
  logic pe_done = 1'b0;
  logic pe_err = 1'b0;
  logic [3:0] pe_err_pat = 4'd0;
  logic [7:0] res_code;
  logic [8:0] res_offset;
  logic [3:0] res_pat;
  logic res_fail;

  always #5 clk = ~clk;

  vref_sweep_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .dir_up(dir_up),
    .stop(stop), .settle_cycles(settle_cycles), .wiper_code(wiper_code),
    .busy(busy), .pe_start(pe_start), .pe_single(pe_single), .pe_pat(pe_pat),
    .pe_done(pe_done), .pe_err(pe_err), .pe_err_pat(pe_err_pat),
    .res_code(res_code), .res_offset(res_offset), .res_pat(res_pat),
    .res_fail(res_fail)
  );

  int n_tests = 0;
  int n_fail = 0;
  int passes = 0, full_passes = 0, first_code = -1, last_code = -1;
  int last_gap = -1, last_single = -1, last_pat = -1, since = 0;
  int prev_code = -1, wait_n = 0;
  int err_lo = -1, err_hi = 999, lat = 2;
  logic [3:0] err_pat_val = 4'd0;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pattern engine model
  initial forever begin
    @(negedge clk);
    if (int'(wiper_code) != prev_code) since = 0; else since++;
    prev_code = int'(wiper_code);
    if (pe_done) begin pe_done = 1'b0; pe_err = 1'b0; end
    if (wait_n > 0) begin
      wait_n--;
      if (wait_n == 0) begin
        pe_done = 1'b1;
        pe_err = (int'(wiper_code) <= err_lo) || (int'(wiper_code) >= err_hi);
        pe_err_pat = err_pat_val;
      end
    end else if (pe_start) begin
      passes++;
      if (!pe_single) full_passes++;
      if (passes == 1) first_code = int'(wiper_code);
      last_code = int'(wiper_code);
      last_gap = since;
      last_single = int'(pe_single);
      last_pat = int'(pe_pat);
      wait_n = lat;
    end
  end

  task automatic clear_stats();
    passes = 0; full_passes = 0; first_code = -1; last_code = -1;
  endtask

  task automatic kick(input logic [1:0] m, input logic up);
    clear_stats();
    @(negedge clk);
    mode = m; dir_up = up; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 20000) begin @(negedge clk); k++; end
  endtask

  task automatic t_reset();
    chk("R1 wiper at power-on code", int'(wiper_code), 127);
    chk("R1 busy low", int'(busy), 0);
    chk("R1 pe_start low", int'(pe_start), 0);
    chk("R1 res_code", int'(res_code), 127);
    chk("R1 res_offset", int'(res_offset), 0);
  endtask

  task automatic t_sweep_up_fail();
    settle_cycles = 16'd3; err_lo = -1; err_hi = 130; err_pat_val = 4'd5;
    kick(2'd0, 1'b1);
    chk("R9 busy after start", int'(busy), 1);
    wait_idle();
    chk("R2 first pass at nominal", first_code, 127);
    chk("R3 passes 127..130", passes, 4);
    chk("R2 all full passes", full_passes, 4);
    chk("R4 res_code", int'(res_code), 130);
    chk("R4 res_offset +3", int'($signed(res_offset)), 3);
    chk("R4 res_pat", int'(res_pat), 5);
    chk("R4 res_fail", int'(res_fail), 1);
    chk("R6 settle gap 3", last_gap, 3);
  endtask

  task automatic t_settle();
    settle_cycles = 16'd7; err_lo = -1; err_hi = 129; err_pat_val = 4'd1;
    kick(2'd3, 1'b1);
    wait_idle();
    chk("R6 settle gap 7", last_gap, 7);
    chk("R2 mode 3 acts as sweep", int'(res_code), 129);
  endtask

  task automatic t_sweep_down_fail();
    settle_cycles = 16'd1; err_lo = 120; err_hi = 999; err_pat_val = 4'd9;
    kick(2'd0, 1'b0);
    wait_idle();
    chk("R3 passes 127..120", passes, 8);
    chk("R4 res_code down", int'(res_code), 120);
    chk("R4 res_offset -7", int'($signed(res_offset)), -7);
    chk("R4 res_pat down", int'(res_pat), 9);
    chk("R4 res_fail down", int'(res_fail), 1);
  endtask

  task automatic t_scope();
    settle_cycles = 16'd0; err_lo = 999; err_hi = 0; err_pat_val = 4'd2;
    kick(2'd2, 1'b1);
    while (passes < 3) @(negedge clk);
    chk("R8 wiper at recorded code", int'(wiper_code), 120);
    chk("R8 single pattern", last_single, 1);
    chk("R8 replayed pattern", last_pat, 9);
    chk("R8 errors do not end scope", int'(busy), 1);
    stop = 1'b1;
    wait_idle();
    stop = 1'b0;
    chk("R8 stop ends scope", int'(busy), 0);
    chk("R8 record kept", int'(res_pat), 9);
  endtask

  task automatic t_loop();
    settle_cycles = 16'd2; err_lo = 999; err_hi = 0;
    kick(2'd1, 1'b0);
    while (passes < 4) @(negedge clk);
    chk("R7 loop code fixed at nominal", last_code, 127);
    chk("R7 loop full passes", full_passes, passes);
    chk("R7 errors do not end loop", int'(busy), 1);
    stop = 1'b1;
    wait_idle();
    stop = 1'b0;
    chk("R7 stop ends loop", int'(busy), 0);
  endtask

  task automatic t_end_up();
    settle_cycles = 16'd0; err_lo = -1; err_hi = 999;
    kick(2'd0, 1'b1);
    wait_idle();
    chk("R5 passes 127..255", passes, 129);
    chk("R5 end code 255", int'(res_code), 255);
    chk("R5 offset +128", int'($signed(res_offset)), 128);
    chk("R5 no-fail status", int'(res_fail), 0);
    chk("R5 pattern cleared", int'(res_pat), 0);
  endtask

  task automatic t_end_down();
    settle_cycles = 16'd0; err_lo = -1; err_hi = 999;
    kick(2'd0, 1'b0);
    wait_idle();
    chk("R5 passes 127..0", passes, 128);
    chk("R5 end code 0", int'(res_code), 0);
    chk("R5 offset -127", int'($signed(res_offset)), -127);
    chk("R5 no-fail status down", int'(res_fail), 0);
  endtask

  task automatic t_restart_ignored();
    int drops = 0;
    settle_cycles = 16'd2; err_lo = -1; err_hi = 129; err_pat_val = 4'd6;
    kick(2'd0, 1'b1);
    while (passes < 1) @(negedge clk);
    mode = 2'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!busy) drops++;
    wait_idle();
    chk("R9 busy held through run", drops, 0);
    chk("R9 restart ignored passes", passes, 3);
    chk("R9 restart ignored code", int'(res_code), 129);
    chk("R9 restart ignored pat", int'(res_pat), 6);
    chk("R10 one start per pass", full_passes, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep_up_fail();
    t_settle();
    t_sweep_down_fail();
    t_scope();
    t_loop();
    t_end_up();
    t_end_down();
    t_restart_ignored();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule